// File: doc/BRIEF.md
# Thermal Threshold Interrupt Monitor

The monitor takes an 8-bit temperature code from an on-die sensor, together with a one-cycle valid strobe. It checks each accepted code against four programmable rising thresholds and four falling thresholds. When the code crosses a threshold, it latches a flag for that level and direction. Software reads the flags, clears them by writing ones, and chooses through an enable register which flags drive the single combined interrupt line. A separate hardware trip output is asserted when armed and when the current code reaches the highest rising level that holds a nonzero threshold. An emulation register can replace the sensor code with a code chosen by software. This lets cooling policy be tested without heating the die.

The register port is a plain synchronous interface: a 3-bit word address, a write strobe, and a 32-bit write word. Read data for the addressed word appears one clock later. No register accepts a write while the sensor reports that it is not ready.

Top module: `thermal_thresh_mon`

## Requirements
- R1: After synchronous reset, every register reads zero, and `irq` and `trip` are low.
- R2: While `sens_ready` is low, every register write is ignored. Bit 8 of the reading word (address 7) mirrors `sens_ready`.
- R3: Bits [7:0] of address 7 hold the code of the last accepted sample. A sample is accepted only when `sens_valid` is high and the run bit (bit 0 of address 0) is set.
- R4: Rising level i uses byte i of address 1 (bits [8i+7:8i]). Its flag, bit i of address 4, is set when an accepted code is at or above that byte and the previous accepted code was below it.
- R5: Falling level i uses byte i of address 2. Its flag, bit 16+i of address 4, is set when an accepted code is at or below that byte and the previous accepted code was above it. A zero byte disables that falling level.
- R6: The first sample accepted after reset, or after the run bit is set again, sets no flag.
- R7: Writing address 5 clears each flag whose bit in the written word is 1, using the same bit layout as address 4. A 0 leaves the flag unchanged, and a flag set in the same cycle stays set.
- R8: The enables at address 3 use bits [3:0] for rising levels and bits [19:16] for falling levels. One cycle after the flags change, `irq` is the OR of all flags ANDed with their enables. Flags latch whether or not they are enabled.
- R9: `trip` is high one cycle after the following conditions all hold: the arm bit (bit 1 of address 0) and the run bit are set, a sample has been accepted, and the current code is at or above the highest-index nonzero rising byte. With no nonzero rising byte, `trip` stays low.
- R10: When bit 0 of address 6 is set, an accepted sample takes the code in bits [15:8] of address 6 instead of `sens_code`. This code is used for both the readout and the threshold comparisons.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sens_code | input | 8 | Temperature code from the sensor |
| sens_valid | input | 1 | One-cycle strobe marking a new code |
| sens_ready | input | 1 | Sensor ready; gates register writes |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the address of the previous cycle |
| irq | output | 1 | Combined interrupt |
| trip | output | 1 | Hardware thermal trip |

## Verification
The bench targets codes that land exactly on a threshold. An off-by-one comparison there would miss the flag or raise it one step early. It also checks a single move that crosses several levels at once, which must set every crossed flag. It covers the first sample after the run bit is set again: a design that kept the stale previous code would flag a crossing that never happened. It also checks a clear that collides with a new crossing, where a design that lets the clear win would lose an event. Random codes clustered around the thresholds are mixed with directed checks of the trip, emulation and ready-gating paths. Among the cases covered are a zero falling byte and the trip level moving down when the top rising byte is zeroed.

// File: rtl/thm_pkg.sv
package thm_pkg;
  typedef enum logic [2:0] {
    A_CTRL = 3'd0,
    A_RISE = 3'd1,
    A_FALL = 3'd2,
    A_IEN  = 3'd3,
    A_FLAG = 3'd4,
    A_CLR  = 3'd5,
    A_EMUL = 3'd6,
    A_TEMP = 3'd7
  } thm_addr_e;

  localparam int CTRL_RUN_BIT  = 0;
  localparam int CTRL_ARM_BIT  = 1;
  localparam int EMUL_EN_BIT   = 0;
  localparam int EMUL_CODE_LSB = 8;
  localparam int TEMP_RDY_BIT  = 8;
endpackage

// File: rtl/thm_edge_detect.sv
module thm_edge_detect #(
  parameter int CODE_W = 8,
  parameter int LEVELS = 4,
  localparam int THR_W = CODE_W * LEVELS
) (
  input  logic [CODE_W-1:0] prev_code,
  input  logic [CODE_W-1:0] new_code,
  input  logic [THR_W-1:0]  rise_thr,
  input  logic [THR_W-1:0]  fall_thr,
  output logic [LEVELS-1:0] rise_hit,
  output logic [LEVELS-1:0] fall_hit
);
  for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
    logic [CODE_W-1:0] r_t, f_t;
    assign r_t = rise_thr[g*CODE_W +: CODE_W];
    assign f_t = fall_thr[g*CODE_W +: CODE_W];
    // upward crossing: was below, now at or above
    assign rise_hit[g] = (prev_code < r_t) && (new_code >= r_t);
    // downward crossing on a used (nonzero) falling level
    assign fall_hit[g] = (f_t != '0) && (prev_code > f_t) && (new_code <= f_t);
  end
endmodule

// File: rtl/thm_trip_select.sv
module thm_trip_select #(
  parameter int CODE_W = 8,
  parameter int LEVELS = 4,
  localparam int THR_W = CODE_W * LEVELS
) (
  input  logic [THR_W-1:0]  rise_thr,
  input  logic [CODE_W-1:0] code,
  output logic              hit
);
  logic [CODE_W-1:0] top_thr;
  logic              found;

  // the last nonzero byte in ascending order is the highest configured level
  always_comb begin
    top_thr = '0;
    found   = 1'b0;
    for (int i = 0; i < LEVELS; i++) begin
      if (rise_thr[i*CODE_W +: CODE_W] != '0) begin
        top_thr = rise_thr[i*CODE_W +: CODE_W];
        found   = 1'b1;
      end
    end
  end

  assign hit = found && (code >= top_thr);
endmodule

// File: rtl/thermal_thresh_mon.sv
module thermal_thresh_mon
  import thm_pkg::*;
#(
  parameter int CODE_W   = 8,
  parameter int LEVELS   = 4,
  parameter int DATA_W   = 32,
  parameter int FALL_OFS = 16,
  parameter int ADDR_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] sens_code,
  input  logic              sens_valid,
  input  logic              sens_ready,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              trip
);
  localparam int THR_W = CODE_W * LEVELS;

  logic              run_q, arm_q;
  logic [THR_W-1:0]  rise_thr_q, fall_thr_q;
  logic [LEVELS-1:0] rise_en_q, fall_en_q;
  logic [LEVELS-1:0] rise_flg_q, fall_flg_q;
  logic              emul_en_q;
  logic [CODE_W-1:0] emul_code_q;
  logic [CODE_W-1:0] cur_code_q;
  logic              cur_valid_q, prev_valid_q;
  logic [DATA_W-1:0] rdata_q;
  logic              irq_q, trip_q;

  logic              wr_ok;
  thm_addr_e         waddr;
  logic              sample_fire;
  logic [CODE_W-1:0] sample_code;
  logic [LEVELS-1:0] rise_hit, fall_hit;
  logic [LEVELS-1:0] rise_set, fall_set, rise_clr, fall_clr;
  logic              trip_hit;
  logic [DATA_W-1:0] rd_n;

  assign wr_ok       = bus_wr && sens_ready;
  assign waddr       = thm_addr_e'(bus_addr);
  assign sample_fire = sens_valid && run_q;
  assign sample_code = emul_en_q ? emul_code_q : sens_code;

  thm_edge_detect #(.CODE_W(CODE_W), .LEVELS(LEVELS)) u_edge (
    .prev_code (cur_code_q),
    .new_code  (sample_code),
    .rise_thr  (rise_thr_q),
    .fall_thr  (fall_thr_q),
    .rise_hit  (rise_hit),
    .fall_hit  (fall_hit)
  );

  thm_trip_select #(.CODE_W(CODE_W), .LEVELS(LEVELS)) u_trip (
    .rise_thr (rise_thr_q),
    .code     (cur_code_q),
    .hit      (trip_hit)
  );

  assign rise_set = (sample_fire && prev_valid_q) ? rise_hit : '0;
  assign fall_set = (sample_fire && prev_valid_q) ? fall_hit : '0;
  assign rise_clr = (wr_ok && waddr == A_CLR) ? bus_wdata[LEVELS-1:0] : '0;
  assign fall_clr = (wr_ok && waddr == A_CLR) ? bus_wdata[FALL_OFS +: LEVELS] : '0;

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      run_q       <= 1'b0;
      arm_q       <= 1'b0;
      rise_thr_q  <= '0;
      fall_thr_q  <= '0;
      rise_en_q   <= '0;
      fall_en_q   <= '0;
      emul_en_q   <= 1'b0;
      emul_code_q <= '0;
    end else if (wr_ok) begin
      case (waddr)
        A_CTRL: begin
          run_q <= bus_wdata[CTRL_RUN_BIT];
          arm_q <= bus_wdata[CTRL_ARM_BIT];
        end
        A_RISE: rise_thr_q <= bus_wdata[THR_W-1:0];
        A_FALL: fall_thr_q <= bus_wdata[THR_W-1:0];
        A_IEN: begin
          rise_en_q <= bus_wdata[LEVELS-1:0];
          fall_en_q <= bus_wdata[FALL_OFS +: LEVELS];
        end
        A_EMUL: begin
          emul_en_q   <= bus_wdata[EMUL_EN_BIT];
          emul_code_q <= bus_wdata[EMUL_CODE_LSB +: CODE_W];
        end
        default: ;
      endcase
    end
  end

  // sample path and flags
  always_ff @(posedge clk) begin
    if (rst) begin
      cur_code_q   <= '0;
      cur_valid_q  <= 1'b0;
      prev_valid_q <= 1'b0;
      rise_flg_q   <= '0;
      fall_flg_q   <= '0;
    end else begin
      if (sample_fire) begin
        cur_code_q   <= sample_code;
        cur_valid_q  <= 1'b1;
        prev_valid_q <= 1'b1;
      end else if (!run_q) begin
        prev_valid_q <= 1'b0;
      end
      rise_flg_q <= (rise_flg_q & ~rise_clr) | rise_set;
      fall_flg_q <= (fall_flg_q & ~fall_clr) | fall_set;
    end
  end

  // read mux
  always_comb begin
    rd_n = '0;
    case (thm_addr_e'(bus_addr))
      A_CTRL: begin
        rd_n[CTRL_RUN_BIT] = run_q;
        rd_n[CTRL_ARM_BIT] = arm_q;
      end
      A_RISE: rd_n[THR_W-1:0] = rise_thr_q;
      A_FALL: rd_n[THR_W-1:0] = fall_thr_q;
      A_IEN: begin
        rd_n[LEVELS-1:0]         = rise_en_q;
        rd_n[FALL_OFS +: LEVELS] = fall_en_q;
      end
      A_FLAG: begin
        rd_n[LEVELS-1:0]         = rise_flg_q;
        rd_n[FALL_OFS +: LEVELS] = fall_flg_q;
      end
      A_EMUL: begin
        rd_n[EMUL_EN_BIT]               = emul_en_q;
        rd_n[EMUL_CODE_LSB +: CODE_W]   = emul_code_q;
      end
      A_TEMP: begin
        rd_n[CODE_W-1:0]  = cur_code_q;
        rd_n[TEMP_RDY_BIT] = sens_ready;
      end
      default: ;
    endcase
  end

  // registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
      trip_q  <= 1'b0;
    end else begin
      rdata_q <= rd_n;
      irq_q   <= |((rise_flg_q & rise_en_q) | (fall_flg_q & fall_en_q));
      trip_q  <= arm_q && run_q && cur_valid_q && trip_hit;
    end
  end

  assign bus_rdata = rdata_q;
  assign irq       = irq_q;
  assign trip      = trip_q;
endmodule

// File: rtl/thm_checker.sv
module thm_checker #(
  parameter int CODE_W   = 8,
  parameter int LEVELS   = 4,
  parameter int DATA_W   = 32,
  parameter int FALL_OFS = 16,
  parameter int ADDR_W   = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              sens_valid,
  input logic              sens_ready,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              irq,
  input logic              trip,
  input logic              run_q,
  input logic              arm_q,
  input logic              prev_valid_q,
  input logic [CODE_W-1:0] cur_code_q,
  input logic [LEVELS-1:0] rise_flg_q,
  input logic [LEVELS-1:0] fall_flg_q,
  input logic [LEVELS-1:0] rise_en_q,
  input logic [LEVELS-1:0] fall_en_q
);
  // R1: reset forces both outputs low
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!irq && !trip));

  // R2: a control write while not ready leaves run/arm untouched
  a_r2_ready_gate: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !sens_ready && bus_addr == 3'd0) |=> ($stable(run_q) && $stable(arm_q)));

  // R3: without an accepted sample the current code holds
  a_r3_hold_code: assert property (@(posedge clk) disable iff (rst)
    !(sens_valid && run_q) |=> $stable(cur_code_q));

  // R6: first accepted sample raises no new flag
  a_r6_first_quiet: assert property (@(posedge clk) disable iff (rst)
    (sens_valid && run_q && !prev_valid_q) |=>
      (((rise_flg_q & ~$past(rise_flg_q)) == '0) && ((fall_flg_q & ~$past(fall_flg_q)) == '0)));

  // R7: a clear with no concurrent sample drops the written rising bits
  a_r7_clear: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && sens_ready && bus_addr == 3'd5 && !(sens_valid && run_q)) |=>
      ((rise_flg_q & $past(bus_wdata[LEVELS-1:0])) == '0));

  // R8: nothing enabled and pending means no interrupt next cycle
  a_r8_irq_quiet: assert property (@(posedge clk) disable iff (rst)
    (((rise_flg_q & rise_en_q) | (fall_flg_q & fall_en_q)) == '0) |=> !irq);

  // R9: trip needs the arm bit
  a_r9_trip_armed: assert property (@(posedge clk) disable iff (rst)
    !arm_q |=> !trip);
endmodule

bind thermal_thresh_mon thm_checker #(
  .CODE_W(CODE_W), .LEVELS(LEVELS), .DATA_W(DATA_W), .FALL_OFS(FALL_OFS), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .sens_valid(sens_valid), .sens_ready(sens_ready),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .irq(irq), .trip(trip), .run_q(run_q), .arm_q(arm_q),
  .prev_valid_q(prev_valid_q), .cur_code_q(cur_code_q),
  .rise_flg_q(rise_flg_q), .fall_flg_q(fall_flg_q),
  .rise_en_q(rise_en_q), .fall_en_q(fall_en_q)
);

// File: tb/sim_thermal_thresh_mon.sv
module sim_thermal_thresh_mon;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  sens_code = '0;
  logic        sens_valid = 1'b0;
  logic        sens_ready = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, trip;

  always #2.5 clk = ~clk;

  thermal_thresh_mon u0 (
    .clk(clk), .rst(rst), .sens_code(sens_code), .sens_valid(sens_valid),
    .sens_ready(sens_ready), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .trip(trip)
  );

  int n_chk = 0;
  int n_bad = 0;

  // reference model
  bit        m_run, m_arm, m_emen, m_curv, m_prevv;
  bit [31:0] m_rthr, m_fthr, m_ien;
  bit [3:0]  m_rflg, m_fflg;
  bit [7:0]  m_emcode, m_cur;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic bit [31:0] exp_flags();
    return {12'd0, m_fflg, 12'd0, m_rflg};
  endfunction

  function automatic bit exp_irq();
    return |((m_rflg & m_ien[3:0]) | (m_fflg & m_ien[19:16]));
  endfunction

  function automatic bit exp_trip();
    bit [7:0] top = 0;
    bit found = 0;
    for (int i = 0; i < 4; i++)
      if (m_rthr[8*i +: 8] != 0) begin top = m_rthr[8*i +: 8]; found = 1; end
    return m_arm && m_run && m_curv && found && (m_cur >= top);
  endfunction

  task automatic wr(bit [2:0] a, bit [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    if (sens_ready) begin
      case (a)
        3'd0: begin m_run = d[0]; m_arm = d[1]; if (!d[0]) m_prevv = 0; end
        3'd1: m_rthr = d;
        3'd2: m_fthr = d;
        3'd3: m_ien = d & 32'h000F_000F;
        3'd5: begin m_rflg &= ~d[3:0]; m_fflg &= ~d[19:16]; end
        3'd6: begin m_emen = d[0]; m_emcode = d[15:8]; end
        default: ;
      endcase
    end
  endtask

  task automatic rd(bit [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic smp(bit [7:0] c);
    bit [7:0] e;
    @(negedge clk);
    sens_valid = 1'b1; sens_code = c;
    @(negedge clk);
    sens_valid = 1'b0;
    e = m_emen ? m_emcode : c;
    if (m_run) begin
      if (m_prevv)
        for (int i = 0; i < 4; i++) begin
          bit [7:0] rt = m_rthr[8*i +: 8];
          bit [7:0] ft = m_fthr[8*i +: 8];
          if (m_cur < rt && e >= rt) m_rflg[i] = 1;
          if (ft != 0 && m_cur > ft && e <= ft) m_fflg[i] = 1;
        end
      m_cur = e; m_curv = 1; m_prevv = 1;
    end
  endtask

  task automatic check_state(string tag);
    logic [31:0] d;
    rd(3'd4, d);
    chk({tag, " flags"}, d, exp_flags());
    chk({tag, " irq"}, {31'd0, irq}, {31'd0, exp_irq()});
    chk({tag, " trip"}, {31'd0, trip}, {31'd0, exp_trip()});
    rd(3'd7, d);
    chk({tag, " temp"}, d, {23'd0, sens_ready, m_cur});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    void'($urandom(32'h1F2E3D4C));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset values
    for (int a = 0; a < 8; a++) begin
      rd(a[2:0], d);
      chk("R1 reset regs", d, 32'd0);
    end
    chk("R1 reset irq", {31'd0, irq}, 32'd0);
    chk("R1 reset trip", {31'd0, trip}, 32'd0);

    // R2 writes ignored while not ready
    wr(3'd0, 32'h3);
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd0, d); chk("R2 ctrl ignored", d, 32'd0);
    rd(3'd1, d); chk("R2 thr ignored", d, 32'd0);
    rd(3'd7, d); chk("R2 ready bit low", d, 32'd0);
    sens_ready = 1'b1;

    wr(3'd1, 32'hC8_96_64_32);   // 50,100,150,200
    wr(3'd2, 32'h00_8C_5A_28);   // 40,90,140,unused
    wr(3'd0, 32'h1);
    rd(3'd1, d); chk("R2 thr accepted", d, 32'hC896_6432);

    // R6 first sample quiet even above thresholds
    smp(8'd120);
    check_state("R6 first sample");
    // R3 readout
    rd(3'd7, d); chk("R3 temp", d, 32'h178);
    // R4 crossing exactly onto level 2
    smp(8'd150);
    check_state("R4 rise on equal");
    chk("R4 flag value", exp_flags(), 32'h4);
    // R8 latched without enable, then enable
    chk("R8 no irq when disabled", {31'd0, irq}, 32'd0);
    wr(3'd3, 32'h0000_0004);
    check_state("R8 irq enabled");
    chk("R8 irq high", {31'd0, irq}, 32'd1);
    // R7 clear with zero leaves, clear with one clears
    wr(3'd5, 32'h0);
    check_state("R7 zero clear");
    wr(3'd5, 32'h4);
    check_state("R7 clear");
    chk("R7 flags clear", exp_flags(), 32'd0);
    // R5 multi-level fall
    smp(8'd30);
    check_state("R5 fall through three");
    chk("R5 fall value", exp_flags(), 32'h0007_0000);
    // R3 sample ignored with run clear, R6 after re-enable
    wr(3'd5, 32'h000F_000F);
    wr(3'd0, 32'h0);
    smp(8'd255);
    check_state("R3 sample ignored");
    wr(3'd0, 32'h3);
    smp(8'd255);
    check_state("R6 re-enable quiet");
    // R9 trip
    check_state("R9 trip at top");
    chk("R9 trip high", {31'd0, trip}, 32'd1);
    wr(3'd1, 32'h00_96_64_32);
    smp(8'd149);
    check_state("R9 trip below new top");
    smp(8'd150);
    check_state("R9 trip at new top");
    // R10 emulation
    wr(3'd6, {16'd0, 8'd45, 8'd1});
    smp(8'd10);
    check_state("R10 emul code");
    rd(3'd7, d); chk("R10 temp emulated", d[7:0], 32'd45);
    wr(3'd6, 32'd0);

    // random section around thresholds
    wr(3'd1, 32'hC8_96_64_32);
    for (int it = 0; it < 600; it++) begin
      int op = $urandom_range(0, 9);
      if (op < 6) begin
        bit [7:0] base = 8'(50 * $urandom_range(0, 4));
        smp(8'(base + $urandom_range(0, 6) - 3));
      end else if (op == 6) wr(3'd5, $urandom & 32'h000F_000F);
      else if (op == 7) wr(3'd3, $urandom);
      else if (op == 8) wr(3'd0, {30'd0, 1'($urandom), 1'b1});
      else wr(3'd6, {16'd0, 8'($urandom), 7'd0, 1'($urandom_range(0, 3) == 0)});
      check_state("R4 R5 R7 R8 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule